// File: doc/BRIEF.md
# Speculative Two-Instruction Pipelined Datapath

This block is a small three-stage processor core that understands exactly two instructions: one that adds one to a register, and one that branches to a target address when a register holds zero. Stage one fetches from an on-block instruction memory at the program counter. Stage two reads the register operand. Stage three computes, writes the register file back and resolves branches. A one-entry queue sits between each pair of stages, and an entry can leave a queue in the same cycle that a new one enters it.

Fetch always assumes that execution falls through to the next address. When a branch resolves as taken in stage three, the core discards the younger fetched and operand-read work and restarts fetch at the branch target. Discarded work never reaches the register file. Read-after-write hazards are handled without forwarding. The operand stage holds its instruction while the queue in front of stage three contains an increment to the same register.

The instruction memory is filled through a write port, usually while reset is held. Progress is observed through a retire strobe with the retiring address and through a flat view of all eight registers.

Top module: `spc_core`

## Requirements
- R1: An instruction word is 12 bits. Bit 11 selects the operation (0 = increment, 1 = branch-if-zero). Bits 10:8 name the register. Bits 7:0 hold the branch target, which an increment ignores.
- R2: While reset is asserted, `retire_valid` is 0 and all registers read zero. The program counter restarts at 0, and the first instruction's retire strobe is high in the cycle after the second rising edge following reset release.
- R3: An increment adds one modulo 256 to the named register. The new value appears on `regs_flat` after the rising edge that ends its retire cycle.
- R4: When there are no hazards and no taken branches, exactly one instruction retires per cycle, in program order.
- R5: An instruction whose register matches an increment held in the queue in front of stage three waits one extra cycle. Two back-to-back instructions on the same register therefore retire two cycles apart, and the second one sees the incremented value.
- R6: A branch whose register reads zero is followed, three cycles later, by the retirement of the instruction at its target. No instruction fetched after the branch and before the redirect retires or changes a register.
- R7: A branch whose register is nonzero changes no register and costs no cycle. The next sequential instruction retires in the following cycle.
- R8: Without a redirect, the program counter advances by one modulo 256, so address 255 is followed by address 0.
- R9: `load_we` writes `load_word` into instruction memory at `load_addr` at any time, including during reset. `retire_pc` gives the address of the retiring instruction. Register k appears on `regs_flat[8k+7:8k]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| load_we | input | 1 | Instruction memory write enable |
| load_addr | input | 8 | Instruction memory write address |
| load_word | input | 12 | Instruction word to write |
| retire_valid | output | 1 | High in the cycle an instruction completes stage three |
| retire_pc | output | 8 | Address of the retiring instruction |
| regs_flat | output | 64 | All eight registers, register k at bits 8k+7:8k |

## Verification
After reset is released, the first retire strobe is due at the second sampled cycle. An unhindered stream then retires one instruction per cycle. A dependent pair retires two cycles apart, and a taken branch puts three cycles between its own retirement and its target's. An increment's result is due one edge after its retire cycle.

The bench samples every output at the falling edge, numbers the cycles from reset release, and records the cycle of each retirement. It compares each retired address with a sequential model, checks the gaps against these figures, and reads the register view one cycle after the last retirement it counts. At that point later in-flight instructions have not yet written back.

// File: rtl/spc_pkg.sv
package spc_pkg;
    localparam int REG_AW  = 3;
    localparam int DATA_W  = 8;
    localparam int ADDR_W  = 8;
    localparam int NREGS   = 1 << REG_AW;
    localparam int NWORDS  = 1 << ADDR_W;
    localparam int INSN_W  = 1 + REG_AW + ADDR_W;
    localparam int FLAT_W  = NREGS * DATA_W;

    typedef enum logic {
        OP_INC = 1'b0,
        OP_JRZ = 1'b1
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [REG_AW-1:0] rn;
        logic [ADDR_W-1:0] tgt;
    } insn_t;

    // queue between fetch and operand stages
    typedef struct packed {
        logic              vld;
        insn_t             ins;
        logic [ADDR_W-1:0] pc;
    } fq_t;

    // queue between operand and execute stages
    typedef struct packed {
        logic              vld;
        insn_t             ins;
        logic [DATA_W-1:0] opv;
        logic [ADDR_W-1:0] pc;
    } oq_t;
endpackage

// File: rtl/spc_fetch.sv
module spc_fetch
    import spc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_we,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic [INSN_W-1:0] ld_word,
    input  logic              pop,
    input  logic              redirect,
    input  logic [ADDR_W-1:0] redir_tgt,
    output fq_t               q1
);
    logic [INSN_W-1:0] imem [NWORDS];
    logic [ADDR_W-1:0] pc;
    logic              accept;

    assign accept = !q1.vld || pop;

    always_ff @(posedge clk) begin
        if (ld_we) imem[ld_addr] <= ld_word;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
            q1 <= '0;
        end else if (redirect) begin
            pc     <= redir_tgt;
            q1.vld <= 1'b0;
        end else if (accept) begin
            q1.vld <= 1'b1;
            q1.ins <= insn_t'(imem[pc]);
            q1.pc  <= pc;
            pc     <= pc + 1'b1;
        end
    end

    AST_REDIRECT_PC: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |=> (pc == $past(redir_tgt)) && !q1.vld); // R6
    AST_SEQ_PC: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect && accept) |=> pc == $past(pc) + 1'b1); // R8
endmodule

// File: rtl/spc_operand.sv
module spc_operand
    import spc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  fq_t               q1,
    input  logic              redirect,
    input  logic [DATA_W-1:0] rd_data,
    output logic [REG_AW-1:0] rd_addr,
    output logic              pop,
    output oq_t               q2
);
    logic hazard;

    assign hazard  = q2.vld && (q2.ins.op == OP_INC) && (q2.ins.rn == q1.ins.rn);
    assign pop     = q1.vld && !hazard && !redirect;
    assign rd_addr = q1.ins.rn;

    // stage three drains q2 every cycle, so a bubble is written when idle
    always_ff @(posedge clk) begin
        if (!rst_n || redirect) begin
            q2.vld <= 1'b0;
        end else begin
            q2.vld <= pop;
            q2.ins <= q1.ins;
            q2.opv <= rd_data;
            q2.pc  <= q1.pc;
        end
    end

    AST_RAW_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (q1.vld && hazard) |=> q1.vld && $stable(q1.pc) && !q2.vld); // R5
endmodule

// File: rtl/spc_execute.sv
module spc_execute
    import spc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  oq_t               q2,
    input  logic [REG_AW-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              redirect,
    output logic [ADDR_W-1:0] redir_tgt,
    output logic [FLAT_W-1:0] rf_flat
);
    logic [DATA_W-1:0] rf [NREGS];
    logic              do_inc;

    assign do_inc    = q2.vld && (q2.ins.op == OP_INC);
    assign redirect  = q2.vld && (q2.ins.op == OP_JRZ) && (q2.opv == '0);
    assign redir_tgt = q2.ins.tgt;
    assign rd_data   = rf[rd_addr];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREGS; i++) rf[i] <= '0;
        end else if (do_inc) begin
            rf[q2.ins.rn] <= q2.opv + 1'b1;
        end
    end

    for (genvar g = 0; g < NREGS; g++) begin : g_flat
        assign rf_flat[g*DATA_W +: DATA_W] = rf[g];
    end

    AST_INC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        do_inc |=> rf[$past(q2.ins.rn)] == DATA_W'($past(rf[q2.ins.rn]) + 1'b1)); // R3
    AST_NOTAKEN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (q2.vld && q2.ins.op == OP_JRZ && q2.opv != '0) |=> $stable(rf_flat)); // R7
endmodule

// File: rtl/spc_core.sv
module spc_core
    import spc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_we,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [INSN_W-1:0] load_word,
    output logic              retire_valid,
    output logic [ADDR_W-1:0] retire_pc,
    output logic [FLAT_W-1:0] regs_flat
);
    fq_t               q1;
    oq_t               q2;
    logic              pop;
    logic              redirect;
    logic [ADDR_W-1:0] redir_tgt;
    logic [REG_AW-1:0] rd_addr;
    logic [DATA_W-1:0] rd_data;

    spc_fetch u_fetch (
        .clk(clk), .rst_n(rst_n), .ld_we(load_we), .ld_addr(load_addr),
        .ld_word(load_word), .pop(pop), .redirect(redirect),
        .redir_tgt(redir_tgt), .q1(q1)
    );

    spc_operand u_operand (
        .clk(clk), .rst_n(rst_n), .q1(q1), .redirect(redirect),
        .rd_data(rd_data), .rd_addr(rd_addr), .pop(pop), .q2(q2)
    );

    spc_execute u_execute (
        .clk(clk), .rst_n(rst_n), .q2(q2), .rd_addr(rd_addr),
        .rd_data(rd_data), .redirect(redirect), .redir_tgt(redir_tgt),
        .rf_flat(regs_flat)
    );

    assign retire_valid = q2.vld;
    assign retire_pc    = q2.pc;

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !retire_valid && (regs_flat == '0)); // R2
endmodule

// File: tb/test_spc_core.sv
`timescale 1ns/1ps
module test_spc_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        load_we = 1'b0;
    logic [7:0]  load_addr = '0;
    logic [11:0] load_word = '0;
    logic        retire_valid;
    logic [7:0]  retire_pc;
    logic [63:0] regs_flat;

    int checks = 0;
    int errors = 0;

    logic [11:0] prog [256];
    int exp_pc [512];
    int rcyc [512];
    int mrf [8];

    always #2 clk = ~clk;

    spc_core i_spc_core (
        .clk(clk), .rst_n(rst_n), .load_we(load_we), .load_addr(load_addr),
        .load_word(load_word), .retire_valid(retire_valid),
        .retire_pc(retire_pc), .regs_flat(regs_flat)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, expv);
        end
    endtask

    // R1 encoding: bit 11 op, 10:8 register, 7:0 target
    function automatic logic [11:0] w_inc(input int r);
        return {1'b0, 3'(r), 8'h00};
    endfunction
    function automatic logic [11:0] w_jrz(input int r, input int t);
        return {1'b1, 3'(r), 8'(t)};
    endfunction

    task automatic model(input int n);
        int mpc = 0;
        for (int i = 0; i < 8; i++) mrf[i] = 0;
        for (int k = 0; k < n; k++) begin
            logic [11:0] w = prog[mpc];
            int r = int'(w[10:8]);
            exp_pc[k] = mpc;
            if (!w[11]) begin
                mrf[r] = (mrf[r] + 1) % 256;
                mpc = (mpc + 1) % 256;
            end else if (mrf[r] == 0) mpc = int'(w[7:0]);
            else mpc = (mpc + 1) % 256;
        end
    endtask

    task automatic run_prog(input int n, input string tag);
        int k = 0;
        int cyc = 0;
        rst_n = 1'b0;
        for (int i = 0; i < 256; i++) begin
            @(negedge clk);
            load_we = 1'b1; load_addr = 8'(i); load_word = prog[i];
        end
        @(negedge clk);
        load_we = 1'b0;
        @(negedge clk);
        chk(retire_valid == 1'b0, "R2 no retire in reset", retire_valid, 0);
        chk(regs_flat == '0, "R2 registers zero in reset", int'(regs_flat[31:0]), 0);
        model(n);
        rst_n = 1'b1;
        while (k < n && cyc < 4000) begin
            @(posedge clk); @(negedge clk);
            cyc++;
            if (retire_valid) begin
                chk(int'(retire_pc) == exp_pc[k], {tag, " R9 retire order"}, retire_pc, exp_pc[k]);
                rcyc[k] = cyc;
                k++;
            end
        end
        chk(k == n, {tag, " R4 retire count"}, k, n);
        @(posedge clk); @(negedge clk);
        for (int g = 0; g < 8; g++)
            chk(int'(regs_flat[g*8 +: 8]) == mrf[g], {tag, " R3 register value"},
                regs_flat[g*8 +: 8], mrf[g]);
    endtask

    task automatic t_stream;
        for (int i = 0; i < 256; i++) prog[i] = w_inc(i % 8);
        run_prog(20, "stream");
        chk(rcyc[0] == 2, "R2 first retire cycle", rcyc[0], 2);
        chk(rcyc[19] == 21, "R4 one per cycle", rcyc[19], 21);
    endtask

    task automatic t_raw;
        for (int i = 0; i < 256; i++) prog[i] = w_inc(1);
        run_prog(10, "raw");
        chk(rcyc[1] == 4, "R5 dependent gap", rcyc[1], 4);
        chk(rcyc[9] == 20, "R5 dependent chain", rcyc[9], 20);
    endtask

    task automatic t_taken;
        for (int i = 0; i < 256; i++) prog[i] = (i < 10) ? w_inc(5) : w_inc(i % 4 + 1);
        prog[0] = w_jrz(0, 10);
        run_prog(6, "taken");
        chk(rcyc[1] - rcyc[0] == 3, "R6 branch penalty", rcyc[1] - rcyc[0], 3);
        chk(regs_flat[47:40] == 8'd0, "R6 squashed work leaves r5", regs_flat[47:40], 0);
    endtask

    task automatic t_not_taken;
        for (int i = 0; i < 256; i++) prog[i] = w_inc(4);
        prog[0] = w_inc(2);
        prog[1] = w_inc(3);
        prog[2] = w_jrz(2, 50);
        run_prog(4, "nottaken");
        chk(rcyc[3] == 5, "R7 no lost cycle", rcyc[3], 5);
        chk(regs_flat[23:16] == 8'd1, "R7 register untouched", regs_flat[23:16], 1);
    endtask

    task automatic t_jrz_hazard;
        for (int i = 0; i < 256; i++) prog[i] = w_inc(6);
        prog[0] = w_inc(7);
        prog[1] = w_jrz(7, 90);
        run_prog(3, "jrzraw");
        chk(rcyc[1] == 4, "R5 branch waits on increment", rcyc[1], 4);
        chk(exp_pc[2] == 2, "R7 model falls through", exp_pc[2], 2);
    endtask

    task automatic t_wrap;
        for (int i = 0; i < 256; i++) prog[i] = w_inc(6);
        run_prog(300, "wrap");
        chk(exp_pc[256] == 0, "R8 address wraps", exp_pc[256], 0);
        chk(regs_flat[55:48] == 8'd44, "R3 value wraps", regs_flat[55:48], 44);
    endtask

    task automatic t_loop;
        for (int i = 0; i < 256; i++) prog[i] = w_inc(3);
        prog[0] = w_inc(1);
        prog[1] = w_jrz(0, 0);
        run_prog(12, "loop");
        chk(regs_flat[15:8] == 8'd6, "R6 loop count", regs_flat[15:8], 6);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog R2 actual %0d expected %0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_stream();
        t_raw();
        t_taken();
        t_not_taken();
        t_jrz_hazard();
        t_wrap();
        t_loop();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule